// File: doc/BRIEF.md
# Double-Buffered Serial Byte Link Buffer

This block is the byte data path of a link controller that talks to a bit-serial bus. A processor-side port writes transmit bytes and reads received bytes, and a bit strobe paces both directions at one bit per strobe. Each direction has a shift register and a shadow register behind it. Software can therefore queue the next transmit byte, or collect the last received byte, while the current byte is still moving on the bus.

When a transmission starts, the first byte goes straight into the transmit shift register. The empty flag rises once that byte's first bit has left the shift register. From then on, each write refills the shadow register, and the shadow byte is moved into the shift register when the current byte ends. A message is ended on purpose by not writing a byte in time. The transmitter then sends a fixed number of extra logic-1 bits and goes idle. The message therefore stops off a byte boundary, and a receiver reports that as an invalid-symbol error.

On the receive side, bits are gathered while the bus reports an active message. Each complete byte is copied into the receive shadow register and the full flag is set. If a message ends with a partial byte collected, a one-cycle error pulse is raised.

Top module: `byte_link_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, tx_empty=1, tx_active=0, tx_bit=1, rx_full=0 and sym_err=0. rd_data has no defined reset value.
- R2: A write while the transmitter is idle loads the byte directly into the shift register. On the next cycle tx_active=1 and tx_bit carries bit 7. Bits leave most-significant first, and each bit stays on tx_bit until the bit_stb cycle that shifts it out.
- R3: A write clears tx_empty on the next cycle. tx_empty rises again only after the strobe that shifts out the first bit of the byte now in the shift register.
- R4: When the last bit of a byte is strobed out and the shadow holds a byte, that byte becomes the next byte on tx_bit with no gap, and tx_active stays high.
- R5: When the last bit of a byte is strobed out and no byte is waiting (underrun), the transmitter sends TAIL_BITS (default 2) logic-1 bits, one per strobe. It then drops tx_active, with tx_empty=1.
- R6: A write made while the extra 1 bits are being sent is ignored: no further bit is sent and the transmitter returns to idle.
- R7: When the receiver collects 8 bits (strobes while rx_active=1, MSB first), the byte appears on rd_data on the next cycle and rx_full is set.
- R8: A read pulse (rd_en) clears rx_full on the next cycle, unless a byte completes in that same cycle.
- R9: A completed byte overwrites the receive shadow register even if the previous byte was never read.
- R10: When rx_active falls with a partial byte collected, sym_err pulses high for exactly one cycle. A message that ends on a byte boundary gives no pulse. The bit count restarts at zero for the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle bit strobe shared by both directions |
| wr_en | input | 1 | Write pulse for a transmit byte |
| wr_data | input | 8 | Transmit byte |
| tx_empty | output | 1 | Transmit shadow may accept the next byte |
| tx_bit | output | 1 | Serial transmit bit (1 when idle) |
| tx_active | output | 1 | Transmitter is driving a message |
| rx_bit | input | 1 | Serial receive bit, sampled on bit_stb |
| rx_active | input | 1 | Bus reports a message in progress |
| rd_en | input | 1 | Read pulse, clears rx_full |
| rd_data | output | 8 | Last completed received byte |
| rx_full | output | 1 | A new received byte is waiting |
| sym_err | output | 1 | One-cycle pulse: message ended off a byte boundary |

## Verification
The assertions check on every cycle that tx_empty only rises on a strobe and that a write clears it. They also check that only logic 1 is sent during the extra-bit phase, that a message stops only on a strobe, that rx_full rises only with a sampled bit, and that sym_err is a single-cycle pulse after the end of a message. Only the bench scenarios can show the values themselves. These are the exact bit order on the line across back-to-back bytes, the exact number of extra 1 bits, the dropped write during the extra bits, the overwrite of an unread byte, and the absence of an error for a message that ends on a byte boundary. A scoreboard checks each strobed bit against the expected stream.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_TAIL  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/sbl_tx.sv
module sbl_tx
  import sbl_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TAIL_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              tx_bit,
  output logic              tx_active
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TL_W  = $clog2(TAIL_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [TL_W-1:0]  LAST_TAIL = TL_W'(TAIL_BITS - 1);

  tx_state_t         st;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shadow;
  logic              shad_vld;
  logic [CNT_W-1:0]  bcnt;
  logic [TL_W-1:0]   tcnt;
  logic              next_avail;
  logic [DATA_W-1:0] next_byte;

  assign next_avail = wr_en || shad_vld;
  assign next_byte  = wr_en ? wr_data : shadow;
  assign tx_bit     = shreg[DATA_W-1];

  // shadow data storage, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en && st == TX_SHIFT) shadow <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      shreg     <= '1;
      bcnt      <= '0;
      tcnt      <= '0;
      shad_vld  <= 1'b0;
      tx_empty  <= 1'b1;
      tx_active <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (wr_en) begin
            shreg     <= wr_data;
            bcnt      <= '0;
            st        <= TX_SHIFT;
            tx_active <= 1'b1;
            tx_empty  <= 1'b0;
          end
        end
        TX_SHIFT: begin
          if (wr_en) begin
            shad_vld <= 1'b1;
            tx_empty <= 1'b0;
          end
          if (bit_stb) begin
            if (bcnt == LAST_BIT) begin
              bcnt <= '0;
              if (next_avail) begin
                shreg    <= next_byte;
                shad_vld <= 1'b0;
              end else begin
                shreg <= '1;
                tcnt  <= '0;
                st    <= TX_TAIL;
              end
            end else begin
              shreg <= {shreg[DATA_W-2:0], 1'b1};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == '0 && !wr_en && !shad_vld) tx_empty <= 1'b1;
            end
          end
        end
        TX_TAIL: begin
          if (bit_stb) begin
            if (tcnt == LAST_TAIL) begin
              st        <= TX_IDLE;
              tx_active <= 1'b0;
              tx_empty  <= 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  AST_EMPTY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(bit_stb)); // R3
  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st != TX_TAIL) |=> !tx_empty); // R3
  AST_TAIL_ONES: assert property (@(posedge clk) disable iff (rst)
    (st == TX_TAIL) |-> (tx_bit && tx_active)); // R5
  AST_STOP_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_active) |-> ($past(bit_stb) && $past(st == TX_TAIL))); // R5
  AST_TAIL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == TX_TAIL && wr_en) |=> tx_empty); // R6
endmodule

// File: rtl/sbl_rx.sv
module sbl_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              rx_bit,
  input  logic              rx_active,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              sym_err
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bcnt;
  logic              act_q;
  logic              take;
  logic              done;
  logic              ended;

  assign take  = bit_stb && rx_active;
  assign done  = take && (bcnt == LAST_BIT);
  assign ended = act_q && !rx_active;

  // data path without reset: shift register and shadow
  always_ff @(posedge clk) begin
    if (take) shreg   <= {shreg[DATA_W-2:0], rx_bit};
    if (done) rd_data <= {shreg[DATA_W-2:0], rx_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      bcnt    <= '0;
      rx_full <= 1'b0;
      sym_err <= 1'b0;
    end else begin
      act_q   <= rx_active;
      sym_err <= ended && (bcnt != '0);
      if (ended)     bcnt <= '0;
      else if (done) bcnt <= '0;
      else if (take) bcnt <= bcnt + 1'b1;
      if (done)       rx_full <= 1'b1;
      else if (rd_en) rx_full <= 1'b0;
    end
  end

  AST_FULL_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(bit_stb && rx_active)); // R7
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(bit_stb && rx_active)) |=> !rx_full); // R8
  AST_ERR_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    sym_err |-> !$past(rx_active)); // R10
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sym_err |=> !sym_err); // R10
endmodule

// File: rtl/byte_link_buf.sv
module byte_link_buf #(
  parameter int DATA_W    = 8,
  parameter int TAIL_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              tx_bit,
  output logic              tx_active,
  input  logic              rx_bit,
  input  logic              rx_active,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              sym_err
);
  sbl_tx #(.DATA_W(DATA_W), .TAIL_BITS(TAIL_BITS)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tx_empty  (tx_empty),
    .tx_bit    (tx_bit),
    .tx_active (tx_active)
  );

  sbl_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .rx_bit    (rx_bit),
    .rx_active (rx_active),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rx_full   (rx_full),
    .sym_err   (sym_err)
  );

  initial begin
    assert (TAIL_BITS >= 1 && DATA_W >= 2); // R5
  end
endmodule

// File: tb/byte_link_buf_bench.sv
`timescale 1ns/1ps
module byte_link_buf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_empty, tx_bit, tx_active;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_full, sym_err;
  logic       loop_sel = 1'b1;
  logic       drv_bit = 1'b0;
  logic       drv_act = 1'b0;
  logic       rx_bit, rx_active;

  int checks = 0;
  int fails = 0;
  int err_seen = 0;
  int err_base;
  logic exp_q[$];

  assign rx_bit    = loop_sel ? tx_bit : drv_bit;
  assign rx_active = loop_sel ? tx_active : drv_act;

  always #2.5 clk = ~clk;

  byte_link_buf u_byte_link_buf (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .wr_en(wr_en), .wr_data(wr_data),
    .tx_empty(tx_empty), .tx_bit(tx_bit), .tx_active(tx_active),
    .rx_bit(rx_bit), .rx_active(rx_active), .rd_en(rd_en),
    .rd_data(rd_data), .rx_full(rx_full), .sym_err(sym_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // strobe every 4th cycle, updated just after the rising edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #1;
      phase = (phase + 1) % 4;
      bit_stb = (phase == 0);
    end
  end

  // monitor: scoreboard for the transmit bit stream, sym_err pulse count
  always @(negedge clk) begin
    if (!rst) begin
      if (sym_err) err_seen++;
      if (tx_active && bit_stb) begin
        if (exp_q.size() == 0) begin
          chk("R6", {15'd0, tx_bit}, 16'hDEAD);
        end else begin
          logic e;
          e = exp_q.pop_front();
          chk("R2", {15'd0, tx_bit}, {15'd0, e});
        end
      end
    end
  end

  task automatic tx_msg(input logic [23:0] msg, input int n, input bit poke);
    while (tx_active) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = msg[23-8*k -: 8];
      if (k > 0) while (!tx_empty) @(negedge clk);
      for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
      wr_data = b;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R3", {15'd0, tx_empty}, 16'd0);
      if (k == 0) begin
        chk("R2", {15'd0, tx_active}, 16'd1);
        chk("R2", {15'd0, tx_bit}, {15'd0, b[7]});
        while (!bit_stb) @(negedge clk);
        chk("R3", {15'd0, tx_empty}, 16'd0);
        @(negedge clk);
        chk("R3", {15'd0, tx_empty}, 16'd1);
      end else begin
        chk("R4", {15'd0, tx_active}, 16'd1);
      end
    end
    for (int i = 0; i < 2; i++) exp_q.push_back(1'b1);
    if (poke) begin
      while (exp_q.size() > 2) @(negedge clk);
      @(negedge clk);
      wr_data = 8'hA5;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
    while (tx_active) @(negedge clk);
    chk("R5", 16'(exp_q.size()), 16'd0);
    chk("R5", {15'd0, tx_empty}, 16'd1);
    if (poke) begin
      repeat (16) @(negedge clk);
      chk("R6", {15'd0, tx_active}, 16'd0);
      chk("R6", {15'd0, tx_bit}, 16'd1);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_msg(input logic [15:0] data, input int nbits);
    @(negedge clk);
    drv_act = 1'b1;
    for (int i = nbits - 1; i >= 0; i--) begin
      drv_bit = data[i];
      while (!bit_stb) @(negedge clk);
      @(negedge clk);
    end
    drv_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8", {15'd0, rx_full}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {15'd0, tx_empty}, 16'd1);
    chk("R1", {15'd0, tx_active}, 16'd0);
    chk("R1", {15'd0, rx_full}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {15'd0, tx_bit}, 16'd1);
    chk("R1", {15'd0, sym_err}, 16'd0);
    chk("R1", {15'd0, tx_empty}, 16'd1);

    // single byte in loopback, underrun tail seen as an error by the receiver
    err_base = err_seen;
    tx_msg(24'h960000, 1, 1'b0);
    chk("R7", {15'd0, rx_full}, 16'd1);
    chk("R7", {8'd0, rd_data}, 16'h0096);
    chk("R10", 16'(err_seen - err_base), 16'd1);
    do_read();

    // three back-to-back bytes, none read: last one kept
    err_base = err_seen;
    tx_msg(24'h12F06D, 3, 1'b0);
    chk("R9", {8'd0, rd_data}, 16'h006D);
    chk("R9", {15'd0, rx_full}, 16'd1);
    chk("R10", 16'(err_seen - err_base), 16'd1);
    do_read();

    // write during the extra 1 bits is dropped
    tx_msg(24'h810000, 1, 1'b1);
    chk("R7", {8'd0, rd_data}, 16'h0081);
    do_read();

    // direct receive: message ending on a byte boundary
    @(negedge clk);
    loop_sel = 1'b0;
    err_base = err_seen;
    rx_msg(16'h003C, 8);
    chk("R10", 16'(err_seen - err_base), 16'd0);
    chk("R7", {8'd0, rd_data}, 16'h003C);
    chk("R7", {15'd0, rx_full}, 16'd1);
    do_read();

    // 11 bits: one byte plus a partial one
    err_base = err_seen;
    rx_msg(16'h02D5, 11);
    chk("R10", 16'(err_seen - err_base), 16'd1);
    chk("R7", {8'd0, rd_data}, 16'h005A);

    // next message starts from bit zero; previous byte unread is overwritten
    err_base = err_seen;
    rx_msg(16'h00C3, 8);
    chk("R9", {8'd0, rd_data}, 16'h00C3);
    chk("R10", 16'(err_seen - err_base), 16'd0);
    do_read();

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule